// File: doc/BRIEF.md
# Bus-Matching FIFO Width Converter

This block is a single-clock FIFO whose storage word is always 72 bits wide. Its write port and its read port can each run at 72, 36 or 18 bits. In any one configuration at most one side is narrow. On a narrow write port, successive writes are packed into one 72-bit word before that word enters storage. On a narrow read port, each stored word is handed out over several reads.

An endian select fixes the order in which the 18-bit lanes of a word are filled or emptied. The lanes are named by position. Lane A is bits 71:54, lane B is 53:36, lane C is 35:18 and lane D is 17:0.

The read side also drives an active-low echo strobe. It marks each cycle in which a freshly read item is presented on the data output, so a downstream receiver can use it as a qualifier. The configuration pins are sampled while reset is held and are then treated as constant.

Top module: `bmf_fifo_top`

## Requirements
- R1: The configuration is the four bits {cfg_little, cfg_match, cfg_in_side, cfg_quarter}, captured on every clock edge during reset. With cfg_match=1:
  - cfg_in_side=1 makes the write port narrow and cfg_in_side=0 makes the read port narrow.
  - cfg_quarter=1 makes the narrow side 18 bits and cfg_quarter=0 makes it 36 bits.
  - cfg_little=1 selects little-endian lane order and cfg_little=0 selects big-endian order.
- R2: With cfg_match=0 both ports are 72 bits wide and the other three configuration bits have no effect. Words are read out in the order written, unchanged.
- R3: 72-bit write with 36-bit read. Big endian reads lanes A,B (bits 71:36) first and then C,D. Little endian reads C,D (bits 35:0) first and then A,B.
- R4: 72-bit write with 18-bit read. Big endian reads lanes A, B, C, D in that order. Little endian reads D, C, B, A in that order.
- R5: 36-bit write with 72-bit read. Big endian puts the first write in A,B and the second in C,D. Little endian puts the first write in C,D and the second in A,B.
- R6: 18-bit write with 72-bit read. Big endian fills A, B, C, D with writes one to four. Little endian fills D, C, B, A with writes one to four.
- R7: A narrow write takes its data from the low bits of wr_data, and the rest of wr_data is ignored. A narrow read presents its data on rd_data[35:0] or rd_data[17:0], with all higher bits zero.
- R8: echo_rd_n is low for exactly the cycle after a clock edge at which rd_en_n=0, rd_cs_n=0 and empty=0. It is high in every other cycle.
- R9: A partly packed word does not clear empty. A packed word becomes readable, and empty falls, in the cycle after the edge that takes its final narrow write.
- R10: On a narrow read port, empty rises only after the last lane of the last stored word has been read.
- R11: full is judged in 72-bit words and is high when DEPTH words are stored. A write that would begin a new word while full is high is ignored. empty and full are never high together.
- R12: Reset clears the pointers and the lane counters. During reset and in the first cycle after it, empty=1, full=0, echo_rd_n=1 and rd_data=0.
- R13: rd_data changes only after a read edge. It is updated at that edge and then holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while it is high |
| cfg_little | input | 1 | 1 selects little-endian lane order |
| cfg_match | input | 1 | 1 enables width conversion; 0 forces 72/72 |
| cfg_in_side | input | 1 | 1 makes the write port the narrow side |
| cfg_quarter | input | 1 | 1 makes the narrow side 18 bits, 0 makes it 36 bits |
| wr_en | input | 1 | Write request |
| wr_data | input | 72 | Write data; narrow writes use the low bits |
| rd_en_n | input | 1 | Active-low read enable |
| rd_cs_n | input | 1 | Active-low read select |
| rd_data | output | 72 | Registered read data; narrow reads on the low bits |
| empty | output | 1 | No complete word is available to read |
| full | output | 1 | DEPTH words are stored |
| echo_rd_n | output | 1 | Active-low strobe marking a cycle with newly read data |

## Verification
The assertions check the following on every cycle:
- the echo strobe against the read request and the empty flag one edge earlier;
- that empty and full are never high together;
- that rd_data holds whenever no read took place;
- that the unused upper bits stay zero in the two narrow read widths.

Lane ordering, packing and unpacking under each endian choice depend on data history, so only the bench's scenarios can show them. The same holds for the point at which a packed word clears empty, the last-lane timing of empty, and writes being dropped while full. A queue-based model predicts these and is compared on every clock in all nine width and endian settings. It also covers a setting with conversion disabled and the other configuration bits set.

// File: rtl/bmf_pkg.sv
`timescale 1ns/1ps
package bmf_pkg;
  localparam int LANE_W = 18;
  localparam int NLANES = 4;
  localparam int WORD_W = LANE_W * NLANES;

  typedef enum logic [1:0] {
    W72 = 2'd0,
    W36 = 2'd1,
    W18 = 2'd2
  } width_e;

  typedef logic [NLANES-1:0][LANE_W-1:0] lanes_t;

  // log2 of the number of lanes covered by one port transfer
  function automatic logic [1:0] lane_shift(width_e w);
    case (w)
      W72:     return 2'd2;
      W36:     return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // index of the final transfer of a word
  function automatic logic [1:0] last_slot(width_e w);
    case (w)
      W72:     return 2'd0;
      W36:     return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  // chunk position (counted from the low end) for transfer number slot
  function automatic logic [1:0] chunk_pos(logic little, logic [1:0] slot, logic [1:0] last);
    return little ? slot : 2'(last - slot);
  endfunction
endpackage

// File: rtl/bmf_cfg_decode.sv
`timescale 1ns/1ps
module bmf_cfg_decode
  import bmf_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cfg_little,
  input  logic   cfg_match,
  input  logic   cfg_in_side,
  input  logic   cfg_quarter,
  output width_e in_w,
  output width_e out_w,
  output logic   little
);
  width_e narrow_w;
  assign narrow_w = cfg_quarter ? W18 : W36;

  always_ff @(posedge clk) begin
    if (rst) begin
      little <= cfg_little & cfg_match;
      if (!cfg_match) begin
        in_w  <= W72;
        out_w <= W72;
      end else if (cfg_in_side) begin
        in_w  <= narrow_w;
        out_w <= W72;
      end else begin
        in_w  <= W72;
        out_w <= narrow_w;
      end
    end
  end
endmodule

// File: rtl/bmf_write_packer.sv
`timescale 1ns/1ps
module bmf_write_packer
  import bmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  width_e            in_w,
  input  logic              little,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              full,
  output logic              push,
  output logic [WORD_W-1:0] push_data
);
  logic [1:0] slot_q;
  lanes_t     stage_q;
  lanes_t     merged;
  lanes_t     din_lanes;
  logic [1:0] lg;
  logic [1:0] last;
  logic [1:0] pos;
  logic [1:0] mask;
  logic       accept;

  assign din_lanes = wr_data;
  assign lg        = lane_shift(in_w);
  assign last      = last_slot(in_w);
  assign pos       = chunk_pos(little, slot_q, last);
  assign mask      = 2'((3'd1 << lg) - 3'd1);

  always_comb begin
    merged = stage_q;
    for (int l = 0; l < NLANES; l++) begin
      if ((2'(l) >> lg) == pos) merged[l] = din_lanes[2'(l) & mask];
    end
  end

  // a new word may only begin while there is room for it
  assign accept    = wr_en && ((slot_q != 2'd0) || !full);
  assign push      = accept && (slot_q == last);
  assign push_data = merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= 2'd0;
      stage_q <= '0;
    end else if (accept) begin
      if (slot_q == last) begin
        slot_q <= 2'd0;
      end else begin
        slot_q  <= 2'(slot_q + 2'd1);
        stage_q <= merged;
      end
    end
  end
endmodule

// File: rtl/bmf_store.sv
`timescale 1ns/1ps
module bmf_store #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wptr_q;
  logic [AW:0]       rptr_q;

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + 1'b1;
      if (pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  assign head  = mem[rptr_q[AW-1:0]];
  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
endmodule

// File: rtl/bmf_read_unpacker.sv
`timescale 1ns/1ps
module bmf_read_unpacker
  import bmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  width_e            out_w,
  input  logic              little,
  input  logic              rd_req,
  input  logic              empty,
  input  logic [WORD_W-1:0] head,
  output logic              pop,
  output logic [WORD_W-1:0] rd_data,
  output logic              echo_rd_n
);
  logic [1:0] slot_q;
  lanes_t     head_lanes;
  lanes_t     sel;
  logic [1:0] lg;
  logic [1:0] last;
  logic [1:0] pos;
  logic [1:0] mask;
  logic       fire;

  assign head_lanes = head;
  assign lg         = lane_shift(out_w);
  assign last       = last_slot(out_w);
  assign pos        = chunk_pos(little, slot_q, last);
  assign mask       = 2'((3'd1 << lg) - 3'd1);
  assign fire       = rd_req && !empty;
  assign pop        = fire && (slot_q == last);

  // move the lanes of the current chunk down to the low end
  always_comb begin
    sel = '0;
    for (int l = 0; l < NLANES; l++) begin
      if ((2'(l) >> lg) == pos) sel[2'(l) & mask] = head_lanes[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q    <= 2'd0;
      rd_data   <= '0;
      echo_rd_n <= 1'b1;
    end else begin
      echo_rd_n <= ~fire;
      if (fire) begin
        rd_data <= sel;
        slot_q  <= (slot_q == last) ? 2'd0 : 2'(slot_q + 2'd1);
      end
    end
  end
endmodule

// File: rtl/bmf_fifo_top.sv
`timescale 1ns/1ps
module bmf_fifo_top
  import bmf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_little,
  input  logic              cfg_match,
  input  logic              cfg_in_side,
  input  logic              cfg_quarter,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en_n,
  input  logic              rd_cs_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              echo_rd_n
);
  width_e            in_w;
  width_e            out_w;
  logic              little;
  logic              push;
  logic [WORD_W-1:0] push_data;
  logic              pop;
  logic [WORD_W-1:0] head;

  bmf_cfg_decode u_cfg (
    .clk(clk), .rst(rst),
    .cfg_little(cfg_little), .cfg_match(cfg_match),
    .cfg_in_side(cfg_in_side), .cfg_quarter(cfg_quarter),
    .in_w(in_w), .out_w(out_w), .little(little)
  );

  bmf_write_packer u_pack (
    .clk(clk), .rst(rst), .in_w(in_w), .little(little),
    .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .push(push), .push_data(push_data)
  );

  bmf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop(pop), .head(head), .empty(empty), .full(full)
  );

  bmf_read_unpacker u_unpack (
    .clk(clk), .rst(rst), .out_w(out_w), .little(little),
    .rd_req(!rd_en_n && !rd_cs_n), .empty(empty), .head(head),
    .pop(pop), .rd_data(rd_data), .echo_rd_n(echo_rd_n)
  );
endmodule

// File: rtl/bmf_fifo_checker.sv
`timescale 1ns/1ps
module bmf_fifo_checker (
  input logic        clk,
  input logic        rst,
  input logic        cfg_match,
  input logic        cfg_in_side,
  input logic        cfg_quarter,
  input logic        rd_en_n,
  input logic        rd_cs_n,
  input logic [71:0] rd_data,
  input logic        empty,
  input logic        full,
  input logic        echo_rd_n
);
  logic out_half;
  logic out_quarter;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_half    <= cfg_match && !cfg_in_side && !cfg_quarter;
      out_quarter <= cfg_match && !cfg_in_side && cfg_quarter;
    end
  end

  AST_ECHO_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!rd_en_n && !rd_cs_n && !empty) |=> !echo_rd_n); // R8
  AST_ECHO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(!rd_en_n && !rd_cs_n && !empty) |=> echo_rd_n); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R11
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    echo_rd_n |-> $stable(rd_data)); // R13
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_half |-> (rd_data[71:36] == 36'd0)); // R7
  AST_QUARTER_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_quarter |-> (rd_data[71:18] == 54'd0)); // R7
endmodule

bind bmf_fifo_top bmf_fifo_checker u_chk (
  .clk(clk), .rst(rst), .cfg_match(cfg_match), .cfg_in_side(cfg_in_side),
  .cfg_quarter(cfg_quarter), .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n),
  .rd_data(rd_data), .empty(empty), .full(full), .echo_rd_n(echo_rd_n)
);

// File: tb/bmf_fifo_top_tb_top.sv
`timescale 1ns/1ps
module bmf_fifo_top_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_little = 1'b0, cfg_match = 1'b0, cfg_in_side = 1'b0, cfg_quarter = 1'b0;
  logic        wr_en = 1'b0;
  logic [71:0] wr_data = '0;
  logic        rd_en_n = 1'b1, rd_cs_n = 1'b1;
  logic [71:0] rd_data;
  logic        empty, full, echo_rd_n;

  int checks = 0;
  int errors = 0;

  // behavioural reference model
  logic [71:0] q[$];
  logic [71:0] wch[$];
  int          in_w = 72, out_w = 72, rcnt = 0;
  bit          little = 0;
  logic [71:0] exp_data = '0;
  logic        exp_echo = 1'b1;
  string       data_tag = "R2";

  always #5 clk = ~clk;

  bmf_fifo_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cfg_little(cfg_little), .cfg_match(cfg_match),
    .cfg_in_side(cfg_in_side), .cfg_quarter(cfg_quarter), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .rd_data(rd_data),
    .empty(empty), .full(full), .echo_rd_n(echo_rd_n)
  );

  function automatic logic [71:0] low_mask(int w);
    logic [71:0] one = 72'd1;
    return (one << w) - one;
  endfunction

  task automatic check(string tag, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (in=%0d out=%0d little=%0d)",
               tag, act, exp, in_w, out_w, little);
    end
  endtask

  task automatic check_outputs();
    check({data_tag, " R13 rd_data"}, rd_data, exp_data);
    check("R8 echo_rd_n", 72'(echo_rd_n), 72'(exp_echo));
    check("R9 R10 empty", 72'(empty), 72'(q.size() == 0));
    check("R11 full", 72'(full), 72'(q.size() == DEPTH));
  endtask

  task automatic step_model(bit we, logic [71:0] wd, bit rd);
    bit emp = (q.size() == 0);
    bit ful = (q.size() == DEPTH);
    if (rd && !emp) begin
      int sh = little ? rcnt * out_w : 72 - (rcnt + 1) * out_w;
      exp_data = (q[0] >> sh) & low_mask(out_w);
      exp_echo = 1'b0;
      rcnt++;
      if (rcnt == 72 / out_w) begin
        q.delete(0);
        rcnt = 0;
      end
    end else begin
      exp_echo = 1'b1;
    end
    if (we && (wch.size() != 0 || !ful)) begin
      wch.push_back(wd & low_mask(in_w));
      if (wch.size() == 72 / in_w) begin
        logic [71:0] word = '0;
        for (int i = 0; i < wch.size(); i++) begin
          if (little) word = word | (wch[i] << (i * in_w));
          else        word = (word << in_w) | wch[i];
        end
        q.push_back(word);
        wch.delete();
      end
    end
  endtask

  task automatic cycle(bit we, logic [71:0] wd, bit ren, bit rcs);
    @(negedge clk);
    check_outputs();
    wr_en   = we;
    wr_data = wd;
    rd_en_n = !ren;
    rd_cs_n = !rcs;
    step_model(we, wd, ren && rcs);
  endtask

  function automatic logic [71:0] rnd72();
    return {8'($urandom), 32'($urandom), 32'($urandom)};
  endfunction

  task automatic run_config(bit le, bit bm, bit side, bit qtr);
    @(negedge clk);
    rst = 1'b1;
    cfg_little = le; cfg_match = bm; cfg_in_side = side; cfg_quarter = qtr;
    wr_en = 1'b0; rd_en_n = 1'b1; rd_cs_n = 1'b1;
    // R1: decode of the configuration bits
    if (!bm) begin
      in_w = 72; out_w = 72; little = 0; data_tag = "R2";
    end else begin
      little = le;
      if (side) begin
        out_w = 72; in_w = qtr ? 18 : 36; data_tag = qtr ? "R1 R6" : "R1 R5";
      end else begin
        in_w = 72; out_w = qtr ? 18 : 36; data_tag = qtr ? "R1 R4 R7" : "R1 R3 R7";
      end
    end
    q.delete(); wch.delete(); rcnt = 0; exp_data = '0; exp_echo = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R12 reset empty", 72'(empty), 72'd1);
    check("R12 reset full", 72'(full), 72'd0);
    check("R12 reset echo", 72'(echo_rd_n), 72'd1);
    check("R12 reset rd_data", rd_data, 72'd0);
    // fill beyond full: extra word starts are ignored (R11), partial words keep empty (R9)
    for (int i = 0; i < DEPTH * (72 / in_w) + 10; i++) cycle(1, rnd72(), 0, 0);
    // drain with occasional deselect (R8, R10)
    for (int i = 0; i < DEPTH * (72 / out_w) + 10; i++) cycle(0, '0, 1, (i % 5) != 0);
    // mixed traffic
    for (int i = 0; i < 300; i++)
      cycle(($urandom % 10) < 6, rnd72(), ($urandom % 2) == 0, ($urandom % 8) != 0);
    for (int i = 0; i < DEPTH * 4 + 10; i++) cycle(0, '0, 1, 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    run_config(0, 0, 0, 0); // R2
    run_config(1, 0, 1, 1); // R2: other bits set, still 72/72
    run_config(0, 1, 0, 0); // R3 big
    run_config(1, 1, 0, 0); // R3 little
    run_config(0, 1, 0, 1); // R4 big
    run_config(1, 1, 0, 1); // R4 little
    run_config(0, 1, 1, 0); // R5 big
    run_config(1, 1, 1, 0); // R5 little
    run_config(0, 1, 1, 1); // R6 big
    run_config(1, 1, 1, 1); // R6 little
    @(negedge clk);
    check_outputs();
    summary();
    $finish;
  end
endmodule